// File: doc/BRIEF.md
# SDRAM Burst Column Sequencer

This block is the column side of a single-data-rate synchronous DRAM. It accepts read and write commands that name a bank and a starting column. For each beat of the resulting burst it emits one internal column strobe that carries the column address, the bank, the direction and the per-byte write enables. A mode port sets how bursts behave: the length, the wrap order, the read latency, and whether writes burst or move a single beat. Read beats appear again on a data-valid output after the programmed latency.

The sequencer is a three-state machine. **ST_IDLE** issues nothing. **ST_FIXED** walks a burst of 2, 4 or 8 beats. **ST_PAGE** walks a full 512-column page with no end of its own. The transitions are as follows. *Start*: a read or write command in any state moves to ST_FIXED or ST_PAGE, or stays in ST_IDLE when the burst is a single beat. *Finish*: the last beat of a fixed burst returns to ST_IDLE. *Stop*: a terminate command in any state returns to ST_IDLE. *Replace*: a new command in ST_FIXED or ST_PAGE restarts the burst. *Hold*: with no command, the machine stays in ST_PAGE or ST_IDLE.

Top module: `sdram_col_seq`

## Requirements
- R1: After reset, col_strobe, rd_valid and mode_err are 0, and the mode is one-beat bursts, sequential order, latency 2, with writes following the burst length.
- R2: A read (cmd_op=01) or write (cmd_op=10) sampled on an edge shows its first beat in the following cycle: col_strobe=1, col_addr=cmd_col, col_bank=cmd_bank, and col_write=1 only for a write. cmd_op=00 is no command.
- R3: Sequential order, for lengths 1, 2, 4 and 8 (mode_len codes 0, 1, 2 and 3): beat i has address bits above log2(N) taken from the start column, and low bits (start+i) mod N. There are exactly N strobes on consecutive cycles.
- R4: Interleaved order (mode_ilv=1): the low log2(N) bits of beat i are the start column's low bits XOR i.
- R5: A full-page burst (mode_len=7, sequential) gives beat i the address (start+i) mod 512, and it keeps going until it is stopped or replaced.
- R6: A terminate (cmd_op=11) gives no strobe in the following cycle and ends the burst. A terminate while idle has no effect.
- R7: A new read or write on any cycle of a burst replaces that burst from the next cycle on.
- R8: A read beat strobed in cycle c appears on rd_valid, with the same rd_bank and rd_col, in cycle c+1 when mode_cl3=0 (latency 2) and in cycle c+2 when mode_cl3=1 (latency 3).
- R9: With mode_bsw=1 every write gives exactly one strobe, and reads still follow the burst length.
- R10: For a write beat, col_wen = ~wr_dqm as sampled on the edge that issues that beat. Bit 0 is the lower byte and bit 1 the upper byte. For read beats col_wen is 0.
- R11: A mode load with mode_len 4, 5 or 6, or with interleaved order and length 7, leaves the previous mode in place and sets mode_err. A legal load applies the new mode and clears mode_err.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; everything is sampled on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_load | input | 1 | Load the mode fields on this edge |
| mode_len | input | 3 | Burst length code: 0=1, 1=2, 2=4, 3=8, 7=full page |
| mode_ilv | input | 1 | 1 = interleaved order, 0 = sequential |
| mode_cl3 | input | 1 | 1 = read latency 3, 0 = read latency 2 |
| mode_bsw | input | 1 | 1 = reads burst, writes are single beats |
| cmd_op | input | 2 | 00 none, 01 read, 10 write, 11 terminate |
| cmd_bank | input | 2 | Bank of the command |
| cmd_col | input | 9 | Starting column |
| wr_dqm | input | 2 | Per-byte write mask, 1 = byte masked |
| col_strobe | output | 1 | One column access this cycle |
| col_write | output | 1 | The access is a write |
| col_bank | output | 2 | Bank of the access |
| col_addr | output | 9 | Column of the access |
| col_wen | output | 2 | Byte write enables of the access |
| rd_valid | output | 1 | Read data beat valid |
| rd_bank | output | 2 | Bank of the read beat |
| rd_col | output | 9 | Column of the read beat |
| mode_err | output | 1 | Last mode load was illegal |

## Verification
A command sampled on edge k shows its first column strobe one cycle later, and beat i shows on edge k+i. The matching read-valid comes one more cycle later at latency 2, or two more at latency 3. A mode load affects mode_err on the next cycle and the burst shape from the next command on. The bench advances a behavioural model on each rising edge, in the order the hardware uses: the beat is decided with the old mode, then the mode is updated. It keeps a two-entry history of read beats so that it can predict the valid output. All outputs are compared at the falling edge, half a period after they settle. Stimulus also changes at the falling edge, so no comparison depends on the order of events at the active edge.

// File: rtl/sdcs_pkg.sv
package sdcs_pkg;

    typedef enum logic [1:0] {
        OP_NONE  = 2'b00,
        OP_READ  = 2'b01,
        OP_WRITE = 2'b10,
        OP_TERM  = 2'b11
    } cmd_op_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'b00,
        ST_FIXED = 2'b01,
        ST_PAGE  = 2'b10
    } seq_state_e;

    localparam logic [2:0] LEN_CODE_PAGE = 3'd7;
    localparam logic [2:0] LEN_CODE_MAXF = 3'd3;

endpackage

// File: rtl/sdcs_mode_reg.sv
module sdcs_mode_reg
    import sdcs_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic [2:0] len_code,
    input  logic       ilv_in,
    input  logic       cl3_in,
    input  logic       bsw_in,
    output logic [1:0] cur_lg2,
    output logic       cur_page,
    output logic       cur_ilv,
    output logic       cur_cl3,
    output logic       cur_bsw,
    output logic       err
);

    logic legal;

    always_comb begin
        if (len_code <= LEN_CODE_MAXF) begin
            legal = 1'b1;
        end else if (len_code == LEN_CODE_PAGE) begin
            legal = !ilv_in;
        end else begin
            legal = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_lg2  <= 2'd0;
            cur_page <= 1'b0;
            cur_ilv  <= 1'b0;
            cur_cl3  <= 1'b0;
            cur_bsw  <= 1'b0;
            err      <= 1'b0;
        end else if (load) begin
            if (legal) begin
                cur_lg2  <= (len_code == LEN_CODE_PAGE) ? 2'd0 : len_code[1:0];
                cur_page <= (len_code == LEN_CODE_PAGE);
                cur_ilv  <= ilv_in;
                cur_cl3  <= cl3_in;
                cur_bsw  <= bsw_in;
                err      <= 1'b0;
            end else begin
                err      <= 1'b1;
            end
        end
    end

    // R11: an interleaved full-page mode is never held
    p_no_ilv_page_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(cur_page && cur_ilv));

    // R11: a rejected load keeps every mode field and flags the error
    p_illegal_keeps_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !legal) |=> (err && $stable(cur_lg2) && $stable(cur_page)
                              && $stable(cur_ilv) && $stable(cur_cl3) && $stable(cur_bsw)));

endmodule

// File: rtl/sdcs_col_gen.sv
module sdcs_col_gen #(
    parameter int COL_W = 9,
    parameter int LG2_W = 2
) (
    input  logic [COL_W-1:0] start,
    input  logic [COL_W-1:0] idx,
    input  logic [LG2_W-1:0] lg2,
    input  logic             page,
    input  logic             ilv,
    output logic [COL_W-1:0] col
);

    logic [COL_W-1:0] low_mask;
    logic [COL_W-1:0] sum;
    logic [COL_W-1:0] low;

    always_comb begin
        sum = start + idx;
        if (page) begin
            low_mask = '1;
        end else begin
            low_mask = (COL_W'(1) << lg2) - COL_W'(1);
        end
        low = (ilv && !page) ? (start ^ idx) : sum;
        col = (start & ~low_mask) | (low & low_mask);
    end

endmodule

// File: rtl/sdcs_rd_pipe.sv
module sdcs_rd_pipe #(
    parameter int COL_W  = 9,
    parameter int BANK_W = 2,
    parameter int DEPTH  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lat_long,
    input  logic              in_vld,
    input  logic [BANK_W-1:0] in_bank,
    input  logic [COL_W-1:0]  in_col,
    output logic              out_vld,
    output logic [BANK_W-1:0] out_bank,
    output logic [COL_W-1:0]  out_col
);

    logic              st_vld  [DEPTH];
    logic [BANK_W-1:0] st_bank [DEPTH];
    logic [COL_W-1:0]  st_col  [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_stage
        if (g == 0) begin : g_head
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    st_vld[0]  <= 1'b0;
                    st_bank[0] <= '0;
                    st_col[0]  <= '0;
                end else begin
                    st_vld[0]  <= in_vld;
                    st_bank[0] <= in_bank;
                    st_col[0]  <= in_col;
                end
            end
        end else begin : g_tail
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    st_vld[g]  <= 1'b0;
                    st_bank[g] <= '0;
                    st_col[g]  <= '0;
                end else begin
                    st_vld[g]  <= st_vld[g-1];
                    st_bank[g] <= st_bank[g-1];
                    st_col[g]  <= st_col[g-1];
                end
            end
        end
    end

    always_comb begin
        if (lat_long) begin
            out_vld  = st_vld[DEPTH-1];
            out_bank = st_bank[DEPTH-1];
            out_col  = st_col[DEPTH-1];
        end else begin
            out_vld  = st_vld[0];
            out_bank = st_bank[0];
            out_col  = st_col[0];
        end
    end

    // R8: latency 2 gives valid one cycle after the strobe, latency 3 two cycles after
    p_lat_short_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!lat_long && $stable(lat_long)) |-> (out_vld == $past(in_vld)));

    p_lat_long_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (lat_long && $stable(lat_long) && $past(lat_long))
            |-> (out_vld == $past(in_vld, 2)));

endmodule

// File: rtl/sdram_col_seq.sv
module sdram_col_seq
    import sdcs_pkg::*;
#(
    parameter int COL_W  = 9,
    parameter int BANK_W = 2,
    parameter int NBYTE  = 2,
    parameter int RD_EXTRA = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_load,
    input  logic [2:0]        mode_len,
    input  logic              mode_ilv,
    input  logic              mode_cl3,
    input  logic              mode_bsw,
    input  logic [1:0]        cmd_op,
    input  logic [BANK_W-1:0] cmd_bank,
    input  logic [COL_W-1:0]  cmd_col,
    input  logic [NBYTE-1:0]  wr_dqm,
    output logic              col_strobe,
    output logic              col_write,
    output logic [BANK_W-1:0] col_bank,
    output logic [COL_W-1:0]  col_addr,
    output logic [NBYTE-1:0]  col_wen,
    output logic              rd_valid,
    output logic [BANK_W-1:0] rd_bank,
    output logic [COL_W-1:0]  rd_col,
    output logic              mode_err
);

    localparam int LG2_W = 2;

    cmd_op_e    op;
    seq_state_e state, nxt_state;

    logic [LG2_W-1:0] m_lg2;
    logic             m_page, m_ilv, m_cl3, m_bsw;

    logic [COL_W-1:0]  b_start, b_idx, last_idx, gen_col;
    logic [LG2_W-1:0]  b_lg2;
    logic              b_ilv, b_wr;
    logic [BANK_W-1:0] b_bank;

    logic              is_rw, cmd_wr, one_beat, ld_burst, inc_idx;
    logic              nb_vld, nb_wr;
    logic [BANK_W-1:0] nb_bank;
    logic [COL_W-1:0]  nb_col;

    assign op = cmd_op_e'(cmd_op);

    sdcs_mode_reg u_mode (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (mode_load),
        .len_code (mode_len),
        .ilv_in   (mode_ilv),
        .cl3_in   (mode_cl3),
        .bsw_in   (mode_bsw),
        .cur_lg2  (m_lg2),
        .cur_page (m_page),
        .cur_ilv  (m_ilv),
        .cur_cl3  (m_cl3),
        .cur_bsw  (m_bsw),
        .err      (mode_err)
    );

    sdcs_col_gen #(.COL_W(COL_W), .LG2_W(LG2_W)) u_gen (
        .start (b_start),
        .idx   (b_idx),
        .lg2   (b_lg2),
        .page  (state == ST_PAGE),
        .ilv   (b_ilv),
        .col   (gen_col)
    );

    // Next-state and beat selection
    always_comb begin
        is_rw     = (op == OP_READ) || (op == OP_WRITE);
        cmd_wr    = (op == OP_WRITE);
        one_beat  = (cmd_wr && m_bsw) || (!m_page && (m_lg2 == '0));
        last_idx  = (COL_W'(1) << b_lg2) - COL_W'(1);
        nxt_state = state;
        ld_burst  = 1'b0;
        inc_idx   = 1'b0;
        nb_vld    = 1'b0;
        nb_wr     = b_wr;
        nb_bank   = b_bank;
        nb_col    = gen_col;
        if (is_rw) begin
            ld_burst = 1'b1;
            nb_vld   = 1'b1;
            nb_wr    = cmd_wr;
            nb_bank  = cmd_bank;
            nb_col   = cmd_col;
            if (one_beat) begin
                nxt_state = ST_IDLE;
            end else if (m_page) begin
                nxt_state = ST_PAGE;
            end else begin
                nxt_state = ST_FIXED;
            end
        end else if (op == OP_TERM) begin
            nxt_state = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    nxt_state = ST_IDLE;
                end
                ST_FIXED: begin
                    nb_vld  = 1'b1;
                    inc_idx = 1'b1;
                    if (b_idx == last_idx) begin
                        nxt_state = ST_IDLE;
                    end
                end
                ST_PAGE: begin
                    nb_vld  = 1'b1;
                    inc_idx = 1'b1;
                end
                default: begin
                    nxt_state = ST_IDLE;
                end
            endcase
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt_state;
        end
    end

    // Burst context
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            b_start <= '0;
            b_idx   <= '0;
            b_lg2   <= '0;
            b_ilv   <= 1'b0;
            b_wr    <= 1'b0;
            b_bank  <= '0;
        end else if (ld_burst) begin
            b_start <= cmd_col;
            b_idx   <= COL_W'(1);
            b_lg2   <= m_lg2;
            b_ilv   <= m_ilv;
            b_wr    <= cmd_wr;
            b_bank  <= cmd_bank;
        end else if (inc_idx) begin
            b_idx   <= b_idx + COL_W'(1);
        end
    end

    // Registered beat outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            col_strobe <= 1'b0;
            col_write  <= 1'b0;
            col_bank   <= '0;
            col_addr   <= '0;
            col_wen    <= '0;
        end else begin
            col_strobe <= nb_vld;
            col_write  <= nb_vld && nb_wr;
            col_bank   <= nb_bank;
            col_addr   <= nb_col;
            col_wen    <= (nb_vld && nb_wr) ? ~wr_dqm : '0;
        end
    end

    sdcs_rd_pipe #(.COL_W(COL_W), .BANK_W(BANK_W), .DEPTH(RD_EXTRA)) u_rd (
        .clk      (clk),
        .rst_n    (rst_n),
        .lat_long (m_cl3),
        .in_vld   (col_strobe && !col_write),
        .in_bank  (col_bank),
        .in_col   (col_addr),
        .out_vld  (rd_valid),
        .out_bank (rd_bank),
        .out_col  (rd_col)
    );

    // R2: a command's first beat carries its own column, bank and direction
    p_first_beat_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((cmd_op == 2'b01) || (cmd_op == 2'b10))
            |=> (col_strobe && (col_addr == $past(cmd_col))
                 && (col_bank == $past(cmd_bank))
                 && (col_write == ($past(cmd_op) == 2'b10))));

    // R6: nothing is strobed in the cycle after a terminate
    p_term_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_op == 2'b11) |=> !col_strobe);

    // R9: in single-write mode a write beat is never followed by a continuation
    p_single_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (col_strobe && col_write && m_bsw && !mode_load && (cmd_op == 2'b00))
            |=> !col_strobe);

    // R10: byte enables of a write's first beat are the inverted mask
    p_wen_first_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_op == 2'b10) |=> (col_wen == ~$past(wr_dqm)));

    // R10: read beats enable no byte
    p_wen_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (col_strobe && !col_write) |-> (col_wen == '0));

endmodule

// File: tb/test_sdram_col_seq.sv
module test_sdram_col_seq;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_load = 1'b0;
    logic [2:0] mode_len = 3'd0;
    logic       mode_ilv = 1'b0;
    logic       mode_cl3 = 1'b0;
    logic       mode_bsw = 1'b0;
    logic [1:0] cmd_op = 2'b00;
    logic [1:0] cmd_bank = 2'd0;
    logic [8:0] cmd_col = 9'd0;
    logic [1:0] wr_dqm = 2'b00;
    logic       col_strobe, col_write, rd_valid, mode_err;
    logic [1:0] col_bank, col_wen, rd_bank;
    logic [8:0] col_addr, rd_col;

    int    checks = 0;
    int    failures = 0;
    bit    done = 1'b0;
    bit    cmp_on = 1'b0;
    string cur_req = "R1";

    always #2.5 clk = ~clk;

    sdram_col_seq i_sdram_col_seq (
        .clk(clk), .rst_n(rst_n), .mode_load(mode_load), .mode_len(mode_len),
        .mode_ilv(mode_ilv), .mode_cl3(mode_cl3), .mode_bsw(mode_bsw),
        .cmd_op(cmd_op), .cmd_bank(cmd_bank), .cmd_col(cmd_col), .wr_dqm(wr_dqm),
        .col_strobe(col_strobe), .col_write(col_write), .col_bank(col_bank),
        .col_addr(col_addr), .col_wen(col_wen), .rd_valid(rd_valid),
        .rd_bank(rd_bank), .rd_col(rd_col), .mode_err(mode_err)
    );

    // ---------------- behavioural reference ----------------
    int m_len, m_ilv, m_cl3, m_bsw, m_err;
    int b_act, b_start, b_idx, b_len, b_ilv, b_wr, b_bank;
    int e_stb, e_wr, e_bank, e_col, e_wen;
    int p_stb, p_rd, p_bank, p_col;
    int e_rv, e_rbank, e_rcol;
    int n_stb, n_wr, n_bank, n_col, n_wen, code_len;

    function automatic int ref_col(int s, int i, int len, int ilv);
        int base;
        if (len == 0) return (s + i) % 512;
        base = s - (s % len);
        if (ilv != 0) return base + ((s % len) ^ i);
        return base + ((s + i) % len);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_len = 1; m_ilv = 0; m_cl3 = 0; m_bsw = 0; m_err = 0;
            b_act = 0; b_start = 0; b_idx = 0; b_len = 1; b_ilv = 0; b_wr = 0; b_bank = 0;
            e_stb = 0; e_wr = 0; e_bank = 0; e_col = 0; e_wen = 0;
            p_stb = 0; p_rd = 0; p_bank = 0; p_col = 0;
            e_rv = 0; e_rbank = 0; e_rcol = 0;
        end else begin
            n_stb = 0; n_wr = 0; n_bank = 0; n_col = 0; n_wen = 0;
            if (cmd_op == 2'b01 || cmd_op == 2'b10) begin
                n_stb = 1; n_wr = (cmd_op == 2'b10); n_bank = cmd_bank; n_col = cmd_col;
                b_len = (n_wr != 0 && m_bsw != 0) ? 1 : m_len;
                b_start = cmd_col; b_idx = 1; b_ilv = m_ilv; b_wr = n_wr; b_bank = cmd_bank;
                b_act = (b_len != 1);
            end else if (cmd_op == 2'b11) begin
                b_act = 0;
            end else if (b_act != 0) begin
                n_stb = 1; n_wr = b_wr; n_bank = b_bank;
                n_col = ref_col(b_start, b_idx, b_len, b_ilv);
                b_idx++;
                if (b_len != 0 && b_idx == b_len) b_act = 0;
            end
            if (n_stb != 0 && n_wr != 0) n_wen = 3 - wr_dqm;
            if (mode_load) begin
                case (mode_len)
                    3'd0: code_len = 1;
                    3'd1: code_len = 2;
                    3'd2: code_len = 4;
                    3'd3: code_len = 8;
                    3'd7: code_len = 0;
                    default: code_len = -1;
                endcase
                if (code_len < 0 || (code_len == 0 && mode_ilv)) begin
                    m_err = 1;
                end else begin
                    m_len = code_len; m_ilv = mode_ilv; m_cl3 = mode_cl3;
                    m_bsw = mode_bsw; m_err = 0;
                end
            end
            // read beats: current visible beat and the one before it
            if (m_cl3 != 0) begin
                e_rv = p_rd; e_rbank = p_bank; e_rcol = p_col;
            end else begin
                e_rv = (e_stb != 0 && e_wr == 0); e_rbank = e_bank; e_rcol = e_col;
            end
            p_rd = (e_stb != 0 && e_wr == 0); p_bank = e_bank; p_col = e_col;
            e_stb = n_stb; e_wr = n_wr; e_bank = n_bank; e_col = n_col; e_wen = n_wen;
        end
    end

    task automatic check(string what, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", cur_req, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (cmp_on && !done) begin
            check("col_strobe", int'(col_strobe), e_stb);
            if (e_stb != 0) begin
                check("col_write", int'(col_write), e_wr);
                check("col_bank", int'(col_bank), e_bank);
                check("col_addr", int'(col_addr), e_col);
                check("col_wen", int'(col_wen), e_wen);
            end
            check("rd_valid", int'(rd_valid), e_rv);
            if (e_rv != 0) begin
                check("rd_bank", int'(rd_bank), e_rbank);
                check("rd_col", int'(rd_col), e_rcol);
            end
            check("mode_err", int'(mode_err), m_err);
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic cmd(input logic [1:0] op, input logic [1:0] bank, input int col, input logic [1:0] dqm);
        cmd_op = op; cmd_bank = bank; cmd_col = 9'(col); wr_dqm = dqm;
        @(negedge clk);
        cmd_op = 2'b00;
    endtask

    task automatic idle(input int n, input logic [1:0] dqm);
        for (int i = 0; i < n; i++) begin
            cmd_op = 2'b00; wr_dqm = dqm;
            @(negedge clk);
        end
    endtask

    task automatic load(input logic [2:0] len, input logic ilv, input logic cl3, input logic bsw);
        mode_load = 1'b1; mode_len = len; mode_ilv = ilv; mode_cl3 = cl3; mode_bsw = bsw;
        @(negedge clk);
        mode_load = 1'b0;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        cur_req = "R1";
        check("reset col_strobe", int'(col_strobe), 0);
        check("reset rd_valid", int'(rd_valid), 0);
        check("reset mode_err", int'(mode_err), 0);
        cmp_on = 1'b1;
        @(negedge clk);
        cmd(2'b01, 2'd0, 9, 2'b00);        // default: single beat
        idle(4, 2'b00);

        cur_req = "R2";
        cmd(2'b01, 2'd2, 291, 2'b00);
        cmd(2'b10, 2'd1, 77, 2'b01);
        idle(4, 2'b00);

        cur_req = "R3";
        load(3'd1, 1'b0, 1'b0, 1'b0); cmd(2'b01, 2'd3, 11, 2'b00); idle(5, 2'b00);
        load(3'd2, 1'b0, 1'b0, 1'b0); cmd(2'b01, 2'd1, 14, 2'b00); idle(6, 2'b00);
        load(3'd3, 1'b0, 1'b0, 1'b0); cmd(2'b01, 2'd0, 509, 2'b00); idle(10, 2'b00);

        cur_req = "R4";
        load(3'd3, 1'b1, 1'b0, 1'b0); cmd(2'b01, 2'd2, 21, 2'b00); idle(10, 2'b00);
        load(3'd2, 1'b1, 1'b0, 1'b0); cmd(2'b10, 2'd3, 10, 2'b00); idle(6, 2'b00);

        cur_req = "R5";
        load(3'd7, 1'b0, 1'b0, 1'b0); cmd(2'b01, 2'd1, 509, 2'b00); idle(530, 2'b00);
        cur_req = "R6";
        cmd(2'b11, 2'd0, 0, 2'b00); idle(4, 2'b00);
        load(3'd3, 1'b0, 1'b0, 1'b0); cmd(2'b10, 2'd0, 40, 2'b00); idle(2, 2'b00);
        cmd(2'b11, 2'd0, 0, 2'b00); idle(4, 2'b00);
        cmd(2'b11, 2'd2, 5, 2'b00); idle(3, 2'b00);   // terminate while idle

        cur_req = "R7";
        cmd(2'b01, 2'd1, 100, 2'b00); idle(2, 2'b00);
        cmd(2'b10, 2'd2, 64, 2'b10); idle(1, 2'b00);
        cmd(2'b01, 2'd3, 7, 2'b00); cmd(2'b01, 2'd0, 200, 2'b00);
        cmd(2'b10, 2'd1, 300, 2'b01); idle(10, 2'b00);

        cur_req = "R8";
        load(3'd2, 1'b0, 1'b1, 1'b0); idle(1, 2'b00);
        cmd(2'b01, 2'd2, 33, 2'b00); idle(2, 2'b00);
        cmd(2'b10, 2'd1, 50, 2'b00); cmd(2'b01, 2'd3, 60, 2'b00); idle(8, 2'b00);

        cur_req = "R9";
        load(3'd2, 1'b0, 1'b0, 1'b1);
        cmd(2'b10, 2'd0, 80, 2'b00); idle(3, 2'b00);
        cmd(2'b01, 2'd0, 81, 2'b00); idle(5, 2'b00);
        cmd(2'b10, 2'd1, 90, 2'b11); cmd(2'b10, 2'd2, 91, 2'b00); idle(4, 2'b00);

        cur_req = "R10";
        load(3'd2, 1'b0, 1'b0, 1'b0);
        cmd(2'b10, 2'd3, 120, 2'b01);
        idle(1, 2'b10); idle(1, 2'b11); idle(1, 2'b00); idle(3, 2'b01);

        cur_req = "R11";
        load(3'd7, 1'b1, 1'b1, 1'b1); idle(1, 2'b00);
        cmd(2'b10, 2'd0, 130, 2'b00); idle(6, 2'b00);   // still length 4, bursting writes
        load(3'd5, 1'b0, 1'b0, 1'b0); idle(1, 2'b00);
        cmd(2'b01, 2'd1, 140, 2'b00); idle(6, 2'b00);
        load(3'd1, 1'b1, 1'b0, 1'b0); idle(1, 2'b00);
        cmd(2'b01, 2'd2, 143, 2'b00); idle(4, 2'b00);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL %s watchdog actual=running expected=finished", cur_req);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule